// File: doc/BRIEF.md
# Three-Axis Sample Byte Formatter

This block sits between the per-axis sample path of a three-axis motion sensor and its register file. At every output-data-rate tick a fresh signed 12-bit sample arrives for each of the X, Y and Z axes, each with its own strobe. The block holds the latest sample of each axis and shows it as a pair of byte registers. It also keeps the new-data and overrun flags that a host polls before it reads.

Two control bits select how the bytes look. The justification bit picks one of two forms: a 16-bit word holding the sample right-justified and sign-extended, or a word holding the sample in its top twelve bits with four zero bits below. The ordering bit picks which address of each pair returns the high byte. The register interface gives one read strobe per data byte. A read of an axis's high byte tells the block that the host has consumed that sample.

Top module: `accel_byte_fmt`

## Requirements
- R1: After synchronous reset every data byte reads 00h and the status byte reads 00h.
- R2: With `just_left` low, each axis word equals the 12-bit sample sign-extended to 16 bits (sample 800h gives F800h).
- R3: With `just_left` high, each axis word equals the sample shifted up by four bits with bits 3:0 zero (sample 800h gives 8000h).
- R4: With `big_end` low, byte index 2a returns bits 7:0 of axis a's word and index 2a+1 returns bits 15:8.
- R5: With `big_end` high, byte index 2a returns bits 15:8 of axis a's word and index 2a+1 returns bits 7:0.
- R6: Byte indices 0..1 belong to X, 2..3 to Y and 4..5 to Z. Byte index i occupies `data_bytes[8i+7:8i]`.
- R7: A strobe on `smp_vld[a]` stores that axis's sample and sets its new-data flag in the next cycle: status bit 0 for X, bit 1 for Y, bit 2 for Z.
- R8: Status bit 3 is high exactly when all three new-data flags are high.
- R9: A read strobe on an axis's high-byte index, as chosen by the current `big_end`, clears that axis's new-data and overrun flags. A read of the low-byte index leaves both flags unchanged.
- R10: A strobe that arrives while the axis's new-data flag is set, and that axis's high byte is not being read in the same cycle, sets the overrun flag: status bit 4 for X, bit 5 for Y, bit 6 for Z.
- R11: Status bit 7 is high exactly when all three overrun flags are high.
- R12: An axis without a strobe keeps its stored sample. A strobe and a high-byte read in the same cycle leave the new-data flag set and do not set the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_smp | input | 12 | X-axis signed sample |
| y_smp | input | 12 | Y-axis signed sample |
| z_smp | input | 12 | Z-axis signed sample |
| smp_vld | input | 3 | Per-axis sample strobe (bit 0 X, bit 1 Y, bit 2 Z) |
| just_left | input | 1 | 1: left-justified 16-bit form, 0: right-justified sign-extended |
| big_end | input | 1 | 1: lower index of each pair returns the high byte |
| rd_stb | input | 6 | One read strobe per byte index |
| data_bytes | output | 48 | Six readable bytes, index i in bits 8i+7:8i |
| status | output | 8 | New-data flags (bits 3:0) and overrun flags (bits 7:4) |

## Verification
The assertions assume that the justification and ordering bits are stable across a clock edge whenever the byte outputs are sampled. They also assume that the read strobes are already decoded, so that a read of one byte raises only that byte's strobe bit. The bench changes every input half a cycle away from the active edge, and it draws the read strobes as independent bits that may hit low and high bytes of several axes at once. Random strobe patterns are mixed with directed cases for the extreme negative sample, simultaneous strobe and read, and overrun on all three axes.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    // Default geometry of one axis
    localparam int DEF_SMP_W  = 12;
    localparam int DEF_WORD_W = 16;
    localparam int NUM_AX     = 3;
    localparam int NUM_BYTES  = 2 * NUM_AX;

    // Status byte bit positions
    localparam int ST_NEW_X   = 0;
    localparam int ST_NEW_ALL = 3;
    localparam int ST_OVR_X   = 4;
    localparam int ST_OVR_ALL = 7;

    typedef enum logic {
        JUST_RIGHT = 1'b0,
        JUST_LEFT  = 1'b1
    } just_e;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } order_e;

    typedef struct packed {
        logic ovr;
        logic fresh;
    } flag_t;

    // Byte index (within a pair) that returns the high byte for an ordering
    function automatic int hi_slot(input order_e ord);
        return (ord == ORD_BIG) ? 0 : 1;
    endfunction

endpackage

// File: rtl/axis_lane.sv
module axis_lane
    import fmt_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [SMP_W-1:0] smp,
    input  logic             clr_hi,
    output logic [SMP_W-1:0] smp_q,
    output flag_t            flg_q
);

    flag_t flg_d;

    always_comb begin
        flg_d.ovr   = (vld & flg_q.fresh & ~clr_hi) | (flg_q.ovr & ~clr_hi);
        flg_d.fresh = vld | (flg_q.fresh & ~clr_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            flg_q <= '0;
        end else begin
            if (vld) smp_q <= smp;
            flg_q <= flg_d;
        end
    end

    p_fresh_after_vld_r7: assert property (@(posedge clk) disable iff (rst)
        vld |=> flg_q.fresh);

    p_ovr_on_repeat_r10: assert property (@(posedge clk) disable iff (rst)
        (vld && flg_q.fresh && !clr_hi) |=> flg_q.ovr);

    p_clear_on_hi_read_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_hi && !vld) |=> (!flg_q.fresh && !flg_q.ovr));

    p_ovr_needs_fresh_r10: assert property (@(posedge clk) disable iff (rst)
        flg_q.ovr |-> flg_q.fresh);

    p_hold_without_vld_r12: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(smp_q));

    p_no_ovr_on_simul_r12: assert property (@(posedge clk) disable iff (rst)
        (vld && clr_hi) |=> (flg_q.fresh && !flg_q.ovr));

endmodule

// File: rtl/word_shaper.sv
module word_shaper
    import fmt_pkg::*;
#(
    parameter int SMP_W  = DEF_SMP_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic [SMP_W-1:0]  smp,
    input  just_e             just,
    output logic [WORD_W-1:0] word
);

    localparam int PAD_W = WORD_W - SMP_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (just == JUST_LEFT)
                    word = {smp, {PAD_W{1'b0}}};
                else
                    word = {{PAD_W{smp[SMP_W-1]}}, smp};
            end
        end else begin : g_nopad
            assign word = smp;
        end
    endgenerate

endmodule

// File: rtl/byte_order.sv
module byte_order
    import fmt_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic [WORD_W-1:0] word,
    input  order_e            ord,
    output logic [7:0]        lo_addr,
    output logic [7:0]        hi_addr
);

    logic [7:0] lsb_byte;
    logic [7:0] msb_byte;

    assign lsb_byte = word[7:0];
    assign msb_byte = word[WORD_W-1 -: 8];

    always_comb begin
        if (ord == ORD_BIG) begin
            lo_addr = msb_byte;
            hi_addr = lsb_byte;
        end else begin
            lo_addr = lsb_byte;
            hi_addr = msb_byte;
        end
    end

endmodule

// File: rtl/accel_byte_fmt.sv
module accel_byte_fmt
    import fmt_pkg::*;
#(
    parameter int SMP_W  = DEF_SMP_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SMP_W-1:0]       x_smp,
    input  logic [SMP_W-1:0]       y_smp,
    input  logic [SMP_W-1:0]       z_smp,
    input  logic [NUM_AX-1:0]      smp_vld,
    input  logic                   just_left,
    input  logic                   big_end,
    input  logic [NUM_BYTES-1:0]   rd_stb,
    output logic [8*NUM_BYTES-1:0] data_bytes,
    output logic [7:0]             status
);

    logic [NUM_AX-1:0][SMP_W-1:0] smp_in;
    just_e                        just;
    order_e                       ord;
    logic [NUM_AX-1:0]            fresh_v;
    logic [NUM_AX-1:0]            ovr_v;

    assign smp_in = {z_smp, y_smp, x_smp};
    assign just   = just_e'(just_left);
    assign ord    = order_e'(big_end);

    generate
        for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
            logic [SMP_W-1:0]  smp_q;
            flag_t             flg;
            logic [WORD_W-1:0] word;
            logic              clr_hi;

            assign clr_hi = rd_stb[2*a + hi_slot(ord)];

            axis_lane #(.SMP_W(SMP_W)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .vld    (smp_vld[a]),
                .smp    (smp_in[a]),
                .clr_hi (clr_hi),
                .smp_q  (smp_q),
                .flg_q  (flg)
            );

            word_shaper #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_shape (
                .smp  (smp_q),
                .just (just),
                .word (word)
            );

            byte_order #(.WORD_W(WORD_W)) u_order (
                .word    (word),
                .ord     (ord),
                .lo_addr (data_bytes[16*a +: 8]),
                .hi_addr (data_bytes[16*a + 8 +: 8])
            );

            assign fresh_v[a] = flg.fresh;
            assign ovr_v[a]   = flg.ovr;
        end
    endgenerate

    always_comb begin
        status = '0;
        for (int a = 0; a < NUM_AX; a++) begin
            status[ST_NEW_X + a] = fresh_v[a];
            status[ST_OVR_X + a] = ovr_v[a];
        end
        status[ST_NEW_ALL] = &fresh_v;
        status[ST_OVR_ALL] = &ovr_v;
    end

    p_left_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (just_left && !big_end) |-> (data_bytes[3:0] == 4'h0));

    p_right_sign_ext_r2: assert property (@(posedge clk) disable iff (rst)
        (!just_left && !big_end) |->
            ((data_bytes[15:11] == 5'h00) || (data_bytes[15:11] == 5'h1f)));

    p_all_new_r8: assert property (@(posedge clk) disable iff (rst)
        status[ST_NEW_ALL] |-> (status[2:0] == 3'b111));

    p_all_ovr_r11: assert property (@(posedge clk) disable iff (rst)
        status[ST_OVR_ALL] |-> status[ST_NEW_ALL]);

endmodule

// File: tb/accel_byte_fmt_test.sv
module accel_byte_fmt_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] x_smp, y_smp, z_smp;
    logic [2:0]  smp_vld;
    logic        just_left, big_end;
    logic [5:0]  rd_stb;
    logic [47:0] data_bytes;
    logic [7:0]  status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [11:0] m_smp [3];
    bit          m_new [3];
    bit          m_ovr [3];

    always #4 clk = ~clk;

    accel_byte_fmt uut (
        .clk(clk), .rst(rst), .x_smp(x_smp), .y_smp(y_smp), .z_smp(z_smp),
        .smp_vld(smp_vld), .just_left(just_left), .big_end(big_end),
        .rd_stb(rd_stb), .data_bytes(data_bytes), .status(status)
    );

    function automatic logic [15:0] exp_word(input logic [11:0] s, input logic jl);
        if (jl) return {s, 4'h0};
        return {{4{s[11]}}, s};
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input logic jl, input logic be);
        logic [15:0] w;
        bit hi;
        w  = exp_word(m_smp[i/2], jl);
        hi = be ? ((i % 2) == 0) : ((i % 2) == 1);
        return hi ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = '0;
        for (int a = 0; a < 3; a++) begin
            s[a]     = m_new[a];
            s[4 + a] = m_ovr[a];
        end
        s[3] = m_new[0] & m_new[1] & m_new[2];
        s[7] = m_ovr[0] & m_ovr[1] & m_ovr[2];
        return s;
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] e;
            e = exp_byte(i, just_left, big_end);
            n_tests++;
            if (data_bytes[8*i +: 8] !== e) begin
                n_fail++;
                $display("FAIL %s byte%0d actual=%h expected=%h", tag, i, data_bytes[8*i +: 8], e);
            end
        end
        n_tests++;
        if (status !== exp_status()) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", tag, status, exp_status());
        end
    endtask

    task automatic step(input logic [2:0] v, input logic [11:0] x, input logic [11:0] y,
                        input logic [11:0] z, input logic [5:0] rd, input logic jl,
                        input logic be, input string tag);
        logic [11:0] s [3];
        @(negedge clk);
        smp_vld = v; x_smp = x; y_smp = y; z_smp = z;
        rd_stb = rd; just_left = jl; big_end = be;
        s[0] = x; s[1] = y; s[2] = z;
        for (int a = 0; a < 3; a++) begin
            bit clr;
            clr = rd[2*a + (be ? 0 : 1)];
            m_ovr[a] = (v[a] & m_new[a] & ~clr) | (m_ovr[a] & ~clr);
            m_new[a] = v[a] | (m_new[a] & ~clr);
            if (v[a]) m_smp[a] = s[a];
        end
        @(negedge clk);
        smp_vld = '0; rd_stb = '0;
        check_all(tag);
    endtask

    initial begin
        int unsigned seed_init;
        for (int a = 0; a < 3; a++) begin
            m_smp[a] = '0; m_new[a] = 0; m_ovr[a] = 0;
        end
        seed_init = $urandom(32'd20240611);
        rst = 1'b1; smp_vld = '0; rd_stb = '0;
        x_smp = '0; y_smp = '0; z_smp = '0; just_left = 0; big_end = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R2: most negative sample, right justified, little endian
        step(3'b001, 12'h800, 12'h000, 12'h000, 6'b0, 0, 0, "R2 neg right");
        // R3: same sample left justified
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b0, 1, 0, "R3 neg left");
        // R6: distinct per-axis values, R4 ordering
        step(3'b110, 12'h000, 12'h123, 12'h7ff, 6'b0, 0, 0, "R6 R4 axis order");
        // R5: swapped ordering
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b0, 0, 1, "R5 big endian");
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b0, 1, 1, "R5 R3 big left");
        // R8: all three fresh
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b0, 0, 0, "R8 all new");
        // R9: low byte of X does not clear, high byte does
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b000001, 0, 0, "R9 low read keeps");
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b000010, 0, 0, "R9 high read clears");
        // R9 with swapped ordering: index 2 is Y high byte
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b000100, 0, 1, "R9 big high read");
        // R10 / R11: overrun on all three
        step(3'b111, 12'h111, 12'h222, 12'h333, 6'b0, 0, 0, "R7 refresh");
        step(3'b111, 12'h9ab, 12'hcde, 12'hf01, 6'b0, 0, 0, "R10 R11 overrun all");
        // R12: simultaneous strobe and high read on X, only strobe on Y
        step(3'b011, 12'h456, 12'h789, 12'h000, 6'b000010, 0, 0, "R12 simul");
        step(3'b000, 12'h0, 12'h0, 12'h0, 6'b101010, 0, 0, "R9 clear all");
        step(3'b001, 12'h5a5, 12'h0, 12'hfff, 6'b0, 1, 0, "R12 others hold");

        for (int it = 0; it < 3000; it++) begin
            logic [2:0] v;
            logic [5:0] rd;
            v  = 3'($urandom);
            rd = 6'($urandom) & 6'($urandom);
            step(v, 12'($urandom), 12'($urandom), 12'($urandom), rd,
                 1'($urandom), 1'($urandom), "R7 R10 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule